// File: doc/BRIEF.md
# UART FIFO Controller with DMA Ready Signalling

This block sits between the host-side register interface and the serial shift registers of a 16550-style UART. It holds a 32-byte transmit queue and a 32-byte receive queue. A single eight-bit control write sets the queue enable, one-shot clears for each queue, the DMA signalling mode and two independent trigger-level selects. The transmit and receive selects use different threshold tables.

The host pushes transmit bytes and the transmit shifter pops them. The receive shifter pushes bytes and the host pops them. Both read ports show the oldest byte without needing a pop first. The block produces two trigger flags, a one-cycle overrun pulse, and the two active-low DMA request pins. In DMA mode 1 the receive request pin holds its asserted state until the receive queue has been fully drained. A receive-timeout pulse from the line logic can also assert that pin.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `cfg_q` is 0 and both counts are 0. Also after reset, `rxrdy_n`=1, `txrdy_n`=0, `rx_trig`=0 and `tx_trig`=1.
- R2: Each queue holds up to 32 bytes and delivers them in arrival order.
  - A push to a full queue is ignored, and so is a pop from an empty queue.
  - A push and a pop in the same cycle are both honoured when each is legal on the pre-cycle count.
  - Counts update on the clock edge after the request.
- R3: A control write with bit 0 set stores bits 7:3 and sets enable (bit 0). Bits 2:1 of `cfg_q` always read 0.
- R4: A control write with bit 0 clear changes only the enable bit, which becomes 0. Bits 7:3 keep their value, and both queues are emptied.
- R5: A control write with bits 0 and 1 set empties the receive queue. A write with bits 0 and 2 set empties the transmit queue. A clear overrides any push or pop to that queue in the same cycle.
- R6: `rx_trig` is 1 when the receive count is at or above a level chosen by bits 7:6: 00→8, 01→16, 10→24, 11→28.
- R7: `tx_trig` is 1 when the transmit count is at or below a level chosen by bits 5:4: 00→16, 01→8, 10→24, 11→30.
- R8: In mode 1 (bits 0 and 3 both set), `txrdy_n` is 1 exactly when the transmit queue holds 32 bytes.
- R9: In mode 1, `rxrdy_n` goes to 0 under either of two conditions, evaluated on the count after the cycle's accesses:
  - the receive count reaches the selected level, using the level in force during that cycle;
  - `rx_timeout` pulses while bytes are present.

  Once at 0, `rxrdy_n` returns to 1 only when the receive queue becomes empty.
- R10: Outside mode 1, `rxrdy_n` is 0 while the receive queue is non-empty, and `txrdy_n` is 0 only while the transmit queue is empty.
- R11: A receive push that finds the queue full, and is not overridden by a clear, raises `rx_overrun` for exactly the following cycle.
- R12: When a queue is non-empty, `rx_rdata` and `tx_rdata` show the oldest byte held in that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 8 | Control write value |
| cfg_q | output | 8 | Stored control value (clear bits read 0) |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Transmit shifter takes a byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| tx_count | output | 6 | Transmit occupancy |
| rx_push | input | 1 | Receive shifter delivers a byte |
| rx_wdata | input | 8 | Receive byte in |
| rx_pop | input | 1 | Host reads a receive byte |
| rx_rdata | output | 8 | Oldest receive byte |
| rx_count | output | 6 | Receive occupancy |
| rx_timeout | input | 1 | Receive timeout pulse |
| rx_overrun | output | 1 | One-cycle overrun pulse |
| rx_trig | output | 1 | Receive level reached |
| tx_trig | output | 1 | Transmit level at or below threshold |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| txrdy_n | output | 1 | Transmit DMA request, active low |

## Verification
Several operations can land in the same cycle: a control write that clears a queue can coincide with a push or pop to that queue, and a push can coincide with a pop when the queue is full or empty. The bench provokes these collisions with directed cycles, and also lets its random stimulus drive control writes, pushes, pops and timeout pulses independently. A reference model in the bench gives the clear priority over the access, evaluates both accesses on the pre-cycle count, and predicts the resulting count, head byte, overrun pulse and request-pin level. Every cycle is judged against that model.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  localparam int FIFO_DEPTH = 32;
  localparam int DATA_W     = 8;
  localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // bit order is behaviour: bit 0 enable, 1 rx clear, 2 tx clear, 3 dma mode
  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       dma_mode;
    logic       tx_clr;
    logic       rx_clr;
    logic       en;
  } fcr_t;

  function automatic cnt_t rx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    rx_level = cnt_t'(8);
      2'd1:    rx_level = cnt_t'(16);
      2'd2:    rx_level = cnt_t'(24);
      default: rx_level = cnt_t'(28);
    endcase
  endfunction

  function automatic cnt_t tx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    tx_level = cnt_t'(16);
      2'd1:    tx_level = cnt_t'(8);
      2'd2:    tx_level = cnt_t'(24);
      default: tx_level = cnt_t'(30);
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output fcr_t       cfg,
  output logic       rx_flush,
  output logic       tx_flush
);
  fcr_t cfg_nxt;

  always_comb begin
    cfg_nxt = cfg;
    if (we) begin
      if (wdata[0]) begin
        cfg_nxt          = fcr_t'(wdata);
        cfg_nxt.rx_clr   = 1'b0;
        cfg_nxt.tx_clr   = 1'b0;
      end else begin
        cfg_nxt.en = 1'b0;
      end
    end
  end

  assign rx_flush = we & (~wdata[0] | wdata[1]);
  assign tx_flush = we & (~wdata[0] | wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_nxt;
  end
endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic [$clog2(DEPTH):0]     count_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr, wptr_nxt, rptr_nxt;
  logic             wr_ok, rd_ok;

  assign wr_ok = push & (count != CW'(DEPTH)) & ~flush;
  assign rd_ok = pop  & (count != '0)         & ~flush;

  always_comb begin
    wptr_nxt  = wptr;
    rptr_nxt  = rptr;
    count_nxt = count;
    if (flush) begin
      wptr_nxt  = '0;
      rptr_nxt  = '0;
      count_nxt = '0;
    end else begin
      if (wr_ok) wptr_nxt = (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr_nxt = (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count_nxt = count + 1'b1;
        2'b01:   count_nxt = count - 1'b1;
        default: count_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_nxt;
      rptr  <= rptr_nxt;
      count <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];
endmodule

// File: rtl/uart_fifo_rdy.sv
module uart_fifo_rdy
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  fcr_t cfg,
  input  cnt_t rx_count,
  input  cnt_t rx_count_nxt,
  input  cnt_t tx_count,
  input  logic rx_timeout,
  output logic rx_trig,
  output logic tx_trig,
  output logic rxrdy_n,
  output logic txrdy_n
);
  logic mode1;
  logic hold_q, hold_nxt;
  cnt_t rx_lvl, tx_lvl;

  assign mode1  = cfg.en & cfg.dma_mode;
  assign rx_lvl = rx_level(cfg.rx_sel);
  assign tx_lvl = tx_level(cfg.tx_sel);

  assign rx_trig = (rx_count >= rx_lvl);
  assign tx_trig = (tx_count <= tx_lvl);

  // hold asserts on level or timeout and persists until the queue drains
  always_comb begin
    hold_nxt = (rx_count_nxt != '0) &&
               ((rx_count_nxt >= rx_lvl) || rx_timeout || hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_nxt;
  end

  assign rxrdy_n = mode1 ? ~hold_q : (rx_count == '0);
  assign txrdy_n = mode1 ? (tx_count == cnt_t'(DEPTH)) : (tx_count != '0);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int WIDTH = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [7:0]             cfg_wdata,
  output logic [7:0]             cfg_q,
  input  logic                   tx_push,
  input  logic [WIDTH-1:0]       tx_wdata,
  input  logic                   tx_pop,
  output logic [WIDTH-1:0]       tx_rdata,
  output logic [$clog2(DEPTH):0] tx_count,
  input  logic                   rx_push,
  input  logic [WIDTH-1:0]       rx_wdata,
  input  logic                   rx_pop,
  output logic [WIDTH-1:0]       rx_rdata,
  output logic [$clog2(DEPTH):0] rx_count,
  input  logic                   rx_timeout,
  output logic                   rx_overrun,
  output logic                   rx_trig,
  output logic                   tx_trig,
  output logic                   rxrdy_n,
  output logic                   txrdy_n
);
  localparam int CW = $clog2(DEPTH) + 1;

  fcr_t          cfg;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] rx_count_nxt, tx_count_nxt;
  logic          ovr_nxt, ovr_q;

  uart_fifo_cfg u_cfg (
    .clk, .rst_n, .we(cfg_we), .wdata(cfg_wdata),
    .cfg, .rx_flush, .tx_flush
  );

  uart_fifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_txq (
    .clk, .rst_n, .flush(tx_flush), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_rdata), .count(tx_count), .count_nxt(tx_count_nxt)
  );

  uart_fifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rxq (
    .clk, .rst_n, .flush(rx_flush), .push(rx_push), .wdata(rx_wdata),
    .pop(rx_pop), .rdata(rx_rdata), .count(rx_count), .count_nxt(rx_count_nxt)
  );

  uart_fifo_rdy #(.DEPTH(DEPTH)) u_rdy (
    .clk, .rst_n, .cfg,
    .rx_count(cnt_t'(rx_count)), .rx_count_nxt(cnt_t'(rx_count_nxt)),
    .tx_count(cnt_t'(tx_count)), .rx_timeout,
    .rx_trig, .tx_trig, .rxrdy_n, .txrdy_n
  );

  assign ovr_nxt = rx_push & (rx_count == CW'(DEPTH)) & ~rx_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_nxt;
  end

  assign rx_overrun = ovr_q;
  assign cfg_q      = cfg;
endmodule

// File: rtl/uart_fifo_chk.sv
module uart_fifo_chk #(
  parameter int DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [7:0]             cfg_wdata,
  input logic [7:0]             cfg_q,
  input logic [$clog2(DEPTH):0] rx_count,
  input logic [$clog2(DEPTH):0] tx_count,
  input logic [$clog2(DEPTH):0] rx_count_nxt,
  input logic [$clog2(DEPTH):0] tx_count_nxt,
  input logic                   rx_push,
  input logic                   rx_flush,
  input logic                   rx_overrun,
  input logic                   rxrdy_n,
  input logic                   txrdy_n
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic mode1;
  assign mode1 = cfg_q[0] & cfg_q[3];

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  assert_count_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rx_count == $past(rx_count_nxt)) && (tx_count == $past(tx_count_nxt)));

  assert_clear_bits_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[2:1] == 2'b00);

  assert_disable_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[0]) |=>
      (!cfg_q[0] && cfg_q[7:3] == $past(cfg_q[7:3]) && rx_count == '0 && tx_count == '0));

  assert_rx_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == '0);

  assert_tx_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode1 |-> (txrdy_n == (tx_count == CW'(DEPTH))));

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !rxrdy_n && !cfg_we) |=> (rx_count == '0 || !rxrdy_n));

  assert_mode0_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode1 |-> (rxrdy_n == (rx_count == '0)));

  assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_count == CW'(DEPTH) && !rx_flush) |=> rx_overrun);

  assert_overrun_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> !rx_overrun || $past(rx_count) == CW'(DEPTH));
endmodule

bind uart_fifo_ctl uart_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .rx_count(rx_count), .tx_count(tx_count),
  .rx_count_nxt(rx_count_nxt), .tx_count_nxt(tx_count_nxt),
  .rx_push(rx_push), .rx_flush(rx_flush), .rx_overrun(rx_overrun),
  .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
);

// File: tb/sim_uart_fifo_ctl.sv
`timescale 1ns/1ps
module sim_uart_fifo_ctl;
  logic clk, rst_n;
  logic cfg_we;  logic [7:0] cfg_wdata; logic [7:0] cfg_q;
  logic tx_push, tx_pop; logic [7:0] tx_wdata, tx_rdata; logic [5:0] tx_count;
  logic rx_push, rx_pop; logic [7:0] rx_wdata, rx_rdata; logic [5:0] rx_count;
  logic rx_timeout, rx_overrun, rx_trig, tx_trig, rxrdy_n, txrdy_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mrx[$];
  logic [7:0] mtx[$];
  logic [7:0] mcfg;
  bit mhold, movr;

  uart_fifo_ctl u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int rxl(input logic [1:0] s);
    int t[4] = '{8, 16, 24, 28};
    return t[s];
  endfunction
  function automatic int txl(input logic [1:0] s);
    int t[4] = '{16, 8, 24, 30};
    return t[s];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    bit m1 = mcfg[0] & mcfg[3];
    int nr = mrx.size();
    int nt = mtx.size();
    chk(int'(rx_count) == nr, "R2 rx_count", rx_count, nr);
    chk(int'(tx_count) == nt, "R2 tx_count", tx_count, nt);
    chk(cfg_q == mcfg, mcfg[0] ? "R3 cfg_q" : "R4 cfg_q", cfg_q, mcfg);
    chk(rx_overrun == movr, "R11 overrun", rx_overrun, movr);
    if (nr != 0) chk(rx_rdata == mrx[0], "R12 rx_rdata", rx_rdata, mrx[0]);
    if (nt != 0) chk(tx_rdata == mtx[0], "R12 tx_rdata", tx_rdata, mtx[0]);
    chk(rx_trig == (nr >= rxl(mcfg[7:6])), "R6 rx_trig", rx_trig, nr >= rxl(mcfg[7:6]));
    chk(tx_trig == (nt <= txl(mcfg[5:4])), "R7 tx_trig", tx_trig, nt <= txl(mcfg[5:4]));
    if (m1) begin
      chk(rxrdy_n == !mhold, "R9 rxrdy_n", rxrdy_n, !mhold);
      chk(txrdy_n == (nt == 32), "R8 txrdy_n", txrdy_n, nt == 32);
    end else begin
      chk(rxrdy_n == (nr == 0), "R10 rxrdy_n", rxrdy_n, nr == 0);
      chk(txrdy_n == (nt != 0), "R10 txrdy_n", txrdy_n, nt != 0);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic cyc(input bit we, input logic [7:0] wd,
                     input bit tp, input logic [7:0] td, input bit to,
                     input bit rp, input logic [7:0] rd, input bit ro, input bit tmo);
    int prx = mrx.size();
    int ptx = mtx.size();
    bit rf = we && (!wd[0] || wd[1]);
    bit tf = we && (!wd[0] || wd[2]);
    cfg_we = we; cfg_wdata = wd; tx_push = tp; tx_wdata = td; tx_pop = to;
    rx_push = rp; rx_wdata = rd; rx_pop = ro; rx_timeout = tmo;
    movr = rp && prx == 32 && !rf;
    if (rf) mrx.delete();
    else begin
      if (ro && prx > 0) void'(mrx.pop_front());
      if (rp && prx < 32) mrx.push_back(rd);
    end
    if (tf) mtx.delete();
    else begin
      if (to && ptx > 0) void'(mtx.pop_front());
      if (tp && ptx < 32) mtx.push_back(td);
    end
    mhold = (mrx.size() != 0) &&
            (mrx.size() >= rxl(mcfg[7:6]) || tmo || mhold);
    if (we) mcfg = wd[0] ? {wd[7:3], 3'b001} : {mcfg[7:1], 1'b0};
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc(0, 8'h00, 0, 8'h00, 0, 0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    cfg_we = 0; cfg_wdata = 0; tx_push = 0; tx_wdata = 0; tx_pop = 0;
    rx_push = 0; rx_wdata = 0; rx_pop = 0; rx_timeout = 0;
    mcfg = 8'h00; mhold = 0; movr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_q == 8'h00, "R1 cfg_q", cfg_q, 0);
    chk(rx_count == 0 && tx_count == 0, "R1 counts", rx_count + tx_count, 0);
    chk(rxrdy_n == 1'b1, "R1 rxrdy_n", rxrdy_n, 1);
    chk(txrdy_n == 1'b0, "R1 txrdy_n", txrdy_n, 0);
    chk(rx_trig == 1'b0 && tx_trig == 1'b1, "R1 trig", {rx_trig, tx_trig}, 1);

    // disabled queues: R10 level pins, R12 show-ahead
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 8'hA0 + 8'(i), 0, 1, 8'h50 + 8'(i), 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 1, 0);

    // R2: fill transmit queue past full, then push+pop at full
    cyc(1, 8'b0000_0001, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 34; i++) cyc(0, 0, 1, 8'(i * 7), 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 8'hEE, 1, 0, 0, 0, 0);
    // R7 each transmit level at the boundary
    for (int s = 0; s < 4; s++) begin
      cyc(1, {2'b00, 2'(s), 4'b0001}, 0, 0, 0, 0, 0, 0, 0);
      while (mtx.size() > txl(2'(s)) + 1) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
      for (int k = 0; k < 2; k++) cyc(0, 0, 1, 8'h33, 0, 0, 0, 0, 0);
    end

    // R8/R9: mode 1, rx level 16
    cyc(1, 8'b0100_1001, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 0, 0, 1, 8'(i + 1), 0, 0);
    while (mrx.size() > 0) cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R9 timeout with two bytes, then timeout on empty queue
    cyc(0, 0, 0, 0, 0, 1, 8'h11, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h22, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R8 fill tx to full in mode 1, then pop once
    while (mtx.size() < 32) cyc(0, 0, 1, 8'h5A, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);

    // R11 overrun, and push+pop at full
    while (mrx.size() < 32) cyc(0, 0, 0, 0, 0, 1, 8'h77, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h99, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'h98, 1, 0);
    idle();

    // R5 rx clear collides with push; tx clear collides with pop
    cyc(1, 8'b1100_1011, 0, 0, 0, 1, 8'hC1, 0, 0);
    cyc(1, 8'b1100_1101, 1, 8'hC2, 1, 1, 8'hC3, 0, 0);
    // R6 receive levels
    for (int s = 0; s < 4; s++) begin
      cyc(1, {2'(s), 6'b00_0011}, 0, 0, 0, 0, 0, 0, 0);
      while (mrx.size() < rxl(2'(s)) + 1) cyc(0, 0, 0, 0, 0, 1, 8'(s), 0, 0);
    end
    // R4 write with bit 0 clear keeps upper bits, empties both
    cyc(1, 8'b0011_0110, 1, 8'h01, 0, 1, 8'h02, 0, 0);
    idle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit we = ($urandom % 48) == 0;
      logic [7:0] wd = 8'($urandom);
      if (($urandom % 8) != 0) wd[0] = 1'b1;
      if (($urandom % 4) != 0) wd[2:1] = 2'b00;
      cyc(we, wd, ($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0,
          ($urandom % 2) == 0, 8'($urandom), ($urandom % 3) == 0,
          ($urandom % 16) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule